// File: doc/BRIEF.md
# Standby Clock Gating Controller

This block decides which internal clock domains stay enabled while the processor sits in a low-power standby state. It also decides which events return the core to normal operation. Three standby levels are offered. A light halt stops only the CPU clock. A deep halt also stops the bus control unit and DMA clocks. Sleep additionally stops every peripheral clock and the high-speed oscillator. On entry to standby the block takes a snapshot of the peripheral clock enables and both oscillator run flags. Standby outputs are driven from that snapshot, so a domain that was running keeps running and a stopped one stays stopped.

A standby request arrives on a valid/ready pair. `req_ready` is high only in run mode. A request presented while `req_ready` is low is dropped rather than held, so the requester must not expect back-pressure to queue it. Wake-up qualification depends on the level. In either halt level, an enabled peripheral interrupt counts only if that peripheral's clock was on in the snapshot. Sleep accepts only NMI, enabled input-port interrupts and the clock-timer interrupt, and the clock-timer interrupt counts only if the low-speed oscillator was running. Leaving sleep takes two steps: one cycle restores the oscillator and bus-side clocks, and the CPU clock follows one cycle later.

Top module: `stby_clkgate_ctrl`

## Requirements
- R1: In run mode `req_ready` is 1. A handshake with `req_mode` equal to 01 (light halt), 10 (deep halt) or 11 (sleep) sets `mode_o` to that code at the next clock edge. `mode_o` reads 00 in run mode.
- R2: A handshake with `req_mode` 00 leaves the block in run mode. Any request made while in standby (`req_ready` 0) is discarded and does not change `mode_o`.
- R3: In light halt, `cpu_clk_en` is 0 and `bcu_clk_en` and `dma_clk_en` are 1.
- R4: In deep halt, `cpu_clk_en`, `bcu_clk_en` and `dma_clk_en` are all 0.
- R5: In both halt levels, `periph_clk_en`, `hosc_en` and `losc_en` equal the values of `periph_en_i`, `hosc_run_i` and `losc_run_i` at the accepting edge, and they ignore later changes to those inputs.
- R6: In sleep (before any wake event), the CPU, bus, DMA, every peripheral clock enable and `hosc_en` are 0, and `losc_en` holds its snapshot value.
- R7: Asserting `rst_n` low at any time, including in standby, immediately returns the block to run mode with `mode_o` 00.
- R8: A high `nmi_i` wakes the block from every standby level.
- R9: In either halt level, the following each wake the block: a peripheral interrupt bit `i` with `irq_en_i[i]` 1 and snapshot clock bit `i` 1; an input-port interrupt with its enable bit 1; the clock-timer interrupt with `ctm_irq_en_i` 1 and the low-speed snapshot 1. An interrupt lacking any one of these conditions is ignored.
- R10: In sleep, peripheral interrupts are ignored. An enabled input-port interrupt wakes the block. The enabled clock-timer interrupt wakes it only if the low-speed snapshot is 1.
- R11: After a wake event from either halt level, the next clock edge restores full run-mode outputs.
- R12: After a wake event from sleep, the next edge produces one restore cycle. In that cycle `hosc_en`, `losc_en` and the peripheral enables take their snapshot values, `bcu_clk_en` and `dma_clk_en` are 1, `cpu_clk_en` is 0 and `mode_o` stays 11. The following edge returns the block to run mode.
- R13: In run mode, `cpu_clk_en`, `bcu_clk_en` and `dma_clk_en` are 1, and `periph_clk_en`, `hosc_en` and `losc_en` follow their inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Standby request valid |
| req_ready | output | 1 | High in run mode; a request is taken only then |
| req_mode | input | 2 | Requested level: 01 light halt, 10 deep halt, 11 sleep |
| periph_en_i | input | NPER | Software peripheral clock enables |
| hosc_run_i | input | 1 | High-speed oscillator run flag |
| losc_run_i | input | 1 | Low-speed oscillator run flag |
| nmi_i | input | 1 | Non-maskable interrupt |
| irq_i | input | NPER | Peripheral interrupt requests |
| irq_en_i | input | NPER | Peripheral interrupt enables (1 = unmasked) |
| port_irq_i | input | NPORT | Input-port interrupt requests |
| port_irq_en_i | input | NPORT | Input-port interrupt enables |
| ctm_irq_i | input | 1 | Clock-timer interrupt |
| ctm_irq_en_i | input | 1 | Clock-timer interrupt enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| bcu_clk_en | output | 1 | Bus control unit clock enable |
| dma_clk_en | output | 1 | DMA clock enable |
| periph_clk_en | output | NPER | Peripheral clock enables |
| hosc_en | output | 1 | High-speed oscillator enable |
| losc_en | output | 1 | Low-speed oscillator enable |
| mode_o | output | 2 | Current mode: 00 run, 01 light halt, 10 deep halt, 11 sleep |

## Verification
The bench targets interrupts that are enabled but arrive from a peripheral whose clock was off in the snapshot. A design that skips the snapshot term would wake from halt on such an interrupt. Peripheral interrupts are raised during sleep, and the clock-timer interrupt is raised with the low-speed oscillator stopped; a design that reuses the halt qualification would leave sleep early on either. The inputs are changed during halt to catch outputs that follow live inputs instead of the snapshot, and requests are issued during standby to catch a controller that re-enters a different level. Wakes from sleep are compared cycle by cycle, so a design that releases the CPU clock together with the oscillator, or one cycle too late, is reported.

// File: rtl/stby_pkg.sv
package stby_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MD_RUN   = 2'b00,
    MD_HALT  = 2'b01,
    MD_HALT2 = 2'b10,
    MD_SLEEP = 2'b11
  } stby_mode_e;
endpackage

// File: rtl/stby_wake_qual.sv
module stby_wake_qual
  import stby_pkg::*;
#(
  parameter int NPER  = 4,
  parameter int NPORT = 2
) (
  input  stby_mode_e       mode,
  input  logic             resume,
  input  logic             nmi_i,
  input  logic [NPER-1:0]  irq_i,
  input  logic [NPER-1:0]  irq_en_i,
  input  logic [NPER-1:0]  psnap,
  input  logic [NPORT-1:0] port_irq_i,
  input  logic [NPORT-1:0] port_irq_en_i,
  input  logic             ctm_irq_i,
  input  logic             ctm_irq_en_i,
  input  logic             lsnap,
  output logic             wake
);
  logic [NPER-1:0]  per_hit;
  logic [NPORT-1:0] port_hit;
  logic             in_standby;
  logic             halt_level;
  logic             ctm_hit;

  // one qualification lane per peripheral: enabled and clocked at entry
  for (genvar i = 0; i < NPER; i++) begin : g_per
    assign per_hit[i] = irq_i[i] & irq_en_i[i] & psnap[i];
  end

  for (genvar j = 0; j < NPORT; j++) begin : g_port
    assign port_hit[j] = port_irq_i[j] & port_irq_en_i[j];
  end

  assign in_standby = (mode != MD_RUN) && !resume;
  assign halt_level = (mode == MD_HALT) || (mode == MD_HALT2);
  assign ctm_hit    = ctm_irq_i & ctm_irq_en_i & lsnap;

  always_comb begin
    wake = 1'b0;
    if (in_standby) begin
      wake = nmi_i | (|port_hit) | ctm_hit;
      if (halt_level) wake = wake | (|per_hit);
    end
  end
endmodule

// File: rtl/stby_mode_fsm.sv
module stby_mode_fsm
  import stby_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [MODE_W-1:0] req_mode,
  input  logic             wake,
  output stby_mode_e       mode,
  output logic             resume,
  output logic             req_ready,
  output logic             take
);
  stby_mode_e mode_q, mode_d;
  logic       res_q, res_d;

  assign req_ready = (mode_q == MD_RUN) && !res_q;
  assign take      = req_valid && req_ready && (req_mode != MD_RUN);

  always_comb begin
    mode_d = mode_q;
    res_d  = res_q;
    if (res_q) begin
      mode_d = MD_RUN;
      res_d  = 1'b0;
    end else if (take) begin
      mode_d = stby_mode_e'(req_mode);
    end else if (wake) begin
      if (mode_q == MD_SLEEP) res_d  = 1'b1;
      else                    mode_d = MD_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_RUN;
      res_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      res_q  <= res_d;
    end
  end

  assign mode   = mode_q;
  assign resume = res_q;
endmodule

// File: rtl/stby_snapshot.sv
module stby_snapshot #(
  parameter int NPER = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [NPER-1:0] periph_en_i,
  input  logic            hosc_run_i,
  input  logic            losc_run_i,
  output logic [NPER-1:0] psnap,
  output logic            hsnap,
  output logic            lsnap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psnap <= '0;
      hsnap <= 1'b0;
      lsnap <= 1'b0;
    end else if (take) begin
      psnap <= periph_en_i;
      hsnap <= hosc_run_i;
      lsnap <= losc_run_i;
    end
  end
endmodule

// File: rtl/stby_gate_out.sv
module stby_gate_out
  import stby_pkg::*;
#(
  parameter int NPER = 4
) (
  input  stby_mode_e      mode,
  input  logic            resume,
  input  logic [NPER-1:0] periph_en_i,
  input  logic            hosc_run_i,
  input  logic            losc_run_i,
  input  logic [NPER-1:0] psnap,
  input  logic            hsnap,
  input  logic            lsnap,
  output logic            cpu_clk_en,
  output logic            bcu_clk_en,
  output logic            dma_clk_en,
  output logic [NPER-1:0] periph_clk_en,
  output logic            hosc_en,
  output logic            losc_en
);
  logic is_run;
  logic keep_per;

  always_comb begin
    is_run     = (mode == MD_RUN);
    cpu_clk_en = is_run;
    bcu_clk_en = is_run || resume || (mode == MD_HALT);
    dma_clk_en = bcu_clk_en;
    keep_per   = resume || (mode == MD_HALT) || (mode == MD_HALT2);
    if (is_run) begin
      hosc_en = hosc_run_i;
      losc_en = losc_run_i;
    end else begin
      hosc_en = keep_per ? hsnap : 1'b0;
      losc_en = lsnap;
    end
  end

  for (genvar i = 0; i < NPER; i++) begin : g_lane
    assign periph_clk_en[i] = is_run ? periph_en_i[i] : (keep_per & psnap[i]);
  end
endmodule

// File: rtl/stby_clkgate_ctrl.sv
module stby_clkgate_ctrl
  import stby_pkg::*;
#(
  parameter int NPER  = 4,
  parameter int NPORT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_mode,
  input  logic [NPER-1:0]   periph_en_i,
  input  logic              hosc_run_i,
  input  logic              losc_run_i,
  input  logic              nmi_i,
  input  logic [NPER-1:0]   irq_i,
  input  logic [NPER-1:0]   irq_en_i,
  input  logic [NPORT-1:0]  port_irq_i,
  input  logic [NPORT-1:0]  port_irq_en_i,
  input  logic              ctm_irq_i,
  input  logic              ctm_irq_en_i,
  output logic              cpu_clk_en,
  output logic              bcu_clk_en,
  output logic              dma_clk_en,
  output logic [NPER-1:0]   periph_clk_en,
  output logic              hosc_en,
  output logic              losc_en,
  output logic [1:0]        mode_o
);
  stby_mode_e      mode_w;
  logic            resume_w;
  logic            take_w;
  logic            wake_w;
  logic [NPER-1:0] psnap_w;
  logic            hsnap_w;
  logic            lsnap_w;

  stby_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .wake      (wake_w),
    .mode      (mode_w),
    .resume    (resume_w),
    .req_ready (req_ready),
    .take      (take_w)
  );

  stby_snapshot #(.NPER(NPER)) u_snap (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (take_w),
    .periph_en_i (periph_en_i),
    .hosc_run_i  (hosc_run_i),
    .losc_run_i  (losc_run_i),
    .psnap       (psnap_w),
    .hsnap       (hsnap_w),
    .lsnap       (lsnap_w)
  );

  stby_wake_qual #(.NPER(NPER), .NPORT(NPORT)) u_wake (
    .mode          (mode_w),
    .resume        (resume_w),
    .nmi_i         (nmi_i),
    .irq_i         (irq_i),
    .irq_en_i      (irq_en_i),
    .psnap         (psnap_w),
    .port_irq_i    (port_irq_i),
    .port_irq_en_i (port_irq_en_i),
    .ctm_irq_i     (ctm_irq_i),
    .ctm_irq_en_i  (ctm_irq_en_i),
    .lsnap         (lsnap_w),
    .wake          (wake_w)
  );

  stby_gate_out #(.NPER(NPER)) u_gate (
    .mode          (mode_w),
    .resume        (resume_w),
    .periph_en_i   (periph_en_i),
    .hosc_run_i    (hosc_run_i),
    .losc_run_i    (losc_run_i),
    .psnap         (psnap_w),
    .hsnap         (hsnap_w),
    .lsnap         (lsnap_w),
    .cpu_clk_en    (cpu_clk_en),
    .bcu_clk_en    (bcu_clk_en),
    .dma_clk_en    (dma_clk_en),
    .periph_clk_en (periph_clk_en),
    .hosc_en       (hosc_en),
    .losc_en       (losc_en)
  );

  assign mode_o = mode_w;
endmodule

// File: rtl/stby_clkgate_chk.sv
module stby_clkgate_chk #(
  parameter int NPER = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [1:0]      req_mode,
  input logic [1:0]      mode_o,
  input logic            resume,
  input logic            nmi_i,
  input logic            cpu_clk_en,
  input logic            bcu_clk_en,
  input logic            dma_clk_en,
  input logic [NPER-1:0] periph_clk_en,
  input logic            hosc_en
);
  a_r1_enter_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mode != 2'b00) |=> (mode_o == $past(req_mode)));

  a_r2_no_level_change: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'b00) |=> (mode_o == $past(mode_o) || mode_o == 2'b00));

  a_r3_light_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b01) |-> (!cpu_clk_en && bcu_clk_en && dma_clk_en));

  a_r4_deep_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10) |-> (!cpu_clk_en && !bcu_clk_en && !dma_clk_en));

  a_r5_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o == 2'b01 || mode_o == 2'b10) && mode_o == $past(mode_o))
      |-> ($stable(periph_clk_en) && $stable(hosc_en)));

  a_r6_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b11 && !resume)
      |-> (!cpu_clk_en && !bcu_clk_en && !dma_clk_en && !hosc_en && periph_clk_en == '0));

  a_r8_nmi_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'b00 && !resume && nmi_i) |=> (mode_o == 2'b00 || resume));

  a_r12_restore_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> (!cpu_clk_en && bcu_clk_en && dma_clk_en && mode_o == 2'b11));

  a_r12_cpu_follows: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> (cpu_clk_en && mode_o == 2'b00));
endmodule

bind stby_clkgate_ctrl stby_clkgate_chk #(.NPER(NPER)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_mode      (req_mode),
  .mode_o        (mode_o),
  .resume        (resume_w),
  .nmi_i         (nmi_i),
  .cpu_clk_en    (cpu_clk_en),
  .bcu_clk_en    (bcu_clk_en),
  .dma_clk_en    (dma_clk_en),
  .periph_clk_en (periph_clk_en),
  .hosc_en       (hosc_en)
);

// File: tb/tb_stby_clkgate_ctrl.sv
`timescale 1ns/1ps
module tb_stby_clkgate_ctrl;
  localparam int NPER  = 4;
  localparam int NPORT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_mode = 2'b00;
  logic [NPER-1:0] periph_en_i = '0;
  logic hosc_run_i = 1'b0, losc_run_i = 1'b0, nmi_i = 1'b0;
  logic [NPER-1:0] irq_i = '0, irq_en_i = '0;
  logic [NPORT-1:0] port_irq_i = '0, port_irq_en_i = '0;
  logic ctm_irq_i = 1'b0, ctm_irq_en_i = 1'b0;
  logic cpu_clk_en, bcu_clk_en, dma_clk_en, hosc_en, losc_en;
  logic [NPER-1:0] periph_clk_en;
  logic [1:0] mode_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stby_clkgate_ctrl #(.NPER(NPER), .NPORT(NPORT)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .periph_en_i(periph_en_i), .hosc_run_i(hosc_run_i),
    .losc_run_i(losc_run_i), .nmi_i(nmi_i), .irq_i(irq_i), .irq_en_i(irq_en_i),
    .port_irq_i(port_irq_i), .port_irq_en_i(port_irq_en_i), .ctm_irq_i(ctm_irq_i),
    .ctm_irq_en_i(ctm_irq_en_i), .cpu_clk_en(cpu_clk_en), .bcu_clk_en(bcu_clk_en),
    .dma_clk_en(dma_clk_en), .periph_clk_en(periph_clk_en), .hosc_en(hosc_en),
    .losc_en(losc_en), .mode_o(mode_o)
  );

  // behavioural reference: level 0..3, plus a "restoring" flag
  int m_lvl = 0;
  bit m_rest = 0;
  bit [NPER-1:0] m_per = '0;
  bit m_hs = 0, m_ls = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl = 0; m_rest = 0; m_per = '0; m_hs = 0; m_ls = 0;
    end else if (m_rest) begin
      m_rest = 0; m_lvl = 0;
    end else if (m_lvl == 0) begin
      if (req_valid && req_mode != 2'b00) begin
        m_lvl = int'(req_mode);
        m_per = periph_en_i; m_hs = hosc_run_i; m_ls = losc_run_i;
      end
    end else begin
      bit go;
      go = nmi_i;
      for (int j = 0; j < NPORT; j++) if (port_irq_i[j] && port_irq_en_i[j]) go = 1;
      if (ctm_irq_i && ctm_irq_en_i && m_ls) go = 1;
      if (m_lvl != 3)
        for (int i = 0; i < NPER; i++) if (irq_i[i] && irq_en_i[i] && m_per[i]) go = 1;
      if (go) begin
        if (m_lvl == 3) m_rest = 1; else m_lvl = 0;
      end
    end
  end

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s got %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // every falling edge: compare all outputs against the reference
  always @(negedge clk) begin
    if (!done) begin
      string tag;
      bit e_cpu, e_bcu, e_dma, e_h, e_l;
      bit [NPER-1:0] e_p;
      if (m_rest)           tag = "R12";
      else if (m_lvl == 0)  tag = "R13";
      else if (m_lvl == 1)  tag = "R3";
      else if (m_lvl == 2)  tag = "R4";
      else                  tag = "R6";
      e_cpu = (m_lvl == 0) && !m_rest;
      e_bcu = e_cpu || m_rest || m_lvl == 1;
      e_dma = e_bcu;
      if (m_lvl == 0) begin
        e_p = periph_en_i; e_h = hosc_run_i; e_l = losc_run_i;
      end else if (m_lvl == 3 && !m_rest) begin
        e_p = '0; e_h = 0; e_l = m_ls;
      end else begin
        e_p = m_per; e_h = m_hs; e_l = m_ls;
      end
      cmp("R1", "mode_o", int'(mode_o), m_lvl);
      cmp("R1", "req_ready", int'(req_ready), int'(m_lvl == 0 && !m_rest));
      cmp(tag, "cpu_clk_en", int'(cpu_clk_en), int'(e_cpu));
      cmp(tag, "bcu_clk_en", int'(bcu_clk_en), int'(e_bcu));
      cmp(tag, "dma_clk_en", int'(dma_clk_en), int'(e_dma));
      cmp(tag, "periph_clk_en", int'(periph_clk_en), int'(e_p));
      cmp(tag, "hosc_en", int'(hosc_en), int'(e_h));
      cmp(tag, "losc_en", int'(losc_en), int'(e_l));
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic request(logic [1:0] lv);
    req_valid = 1'b1; req_mode = lv;
    step();
    req_valid = 1'b0; req_mode = 2'b00;
  endtask

  task automatic quiet();
    nmi_i = 0; irq_i = '0; port_irq_i = '0; ctm_irq_i = 0;
  endtask

  initial begin
    step(2);
    // R7: reset state observed while reset held
    cmp("R7", "mode in reset", int'(mode_o), 0);
    cmp("R7", "cpu in reset", int'(cpu_clk_en), 1);
    rst_n = 1'b1;
    step();

    // R13: run mode follows inputs
    periph_en_i = 4'b0101; hosc_run_i = 1; losc_run_i = 1; step();
    periph_en_i = 4'b1010; hosc_run_i = 0; step();
    periph_en_i = 4'b0101; hosc_run_i = 1; step();

    // R2: valid request with code 00 is ignored
    request(2'b00); step();
    cmp("R2", "mode after 00 request", int'(mode_o), 0);

    // R3/R5: light halt, then change inputs; R2: request during standby
    irq_en_i = 4'b1111;
    request(2'b01);
    periph_en_i = 4'b1111; hosc_run_i = 0; losc_run_i = 0; step(2);
    request(2'b11); step();
    cmp("R2", "mode after request in halt", int'(mode_o), 1);
    cmp("R5", "periph held", int'(periph_clk_en), 'h5);
    // R9: peripheral 1 had no clock at entry: ignored
    irq_i = 4'b0010; step(3);
    cmp("R9", "unclocked irq ignored", int'(mode_o), 1);
    irq_i = 4'b0000; irq_en_i = 4'b1110;
    // R9: peripheral 0 masked: ignored
    irq_i = 4'b0001; step(2);
    cmp("R9", "masked irq ignored", int'(mode_o), 1);
    // R11: peripheral 2 enabled and clocked: wake
    irq_i = 4'b0100; step();
    cmp("R11", "halt wake to run", int'(mode_o), 0);
    quiet(); step();

    // R4/R9: deep halt, port interrupt masked then enabled
    periph_en_i = 4'b0011; hosc_run_i = 1; losc_run_i = 1;
    request(2'b10); step();
    port_irq_i = 2'b10; port_irq_en_i = 2'b01; step(2);
    cmp("R9", "masked port irq ignored", int'(mode_o), 2);
    port_irq_en_i = 2'b11; step();
    cmp("R9", "port irq wake", int'(mode_o), 0);
    quiet(); step();

    // R9/R8: light halt entered with low-speed osc off: timer ignored, NMI wakes
    losc_run_i = 0; ctm_irq_en_i = 1;
    request(2'b01);
    ctm_irq_i = 1; step(2);
    cmp("R9", "timer without osc ignored", int'(mode_o), 1);
    nmi_i = 1; step();
    cmp("R8", "nmi halt wake", int'(mode_o), 0);
    quiet(); step();

    // R6/R10/R12: sleep with low-speed osc on
    losc_run_i = 1; hosc_run_i = 1; periph_en_i = 4'b1001;
    request(2'b11); step();
    irq_i = 4'b1111; irq_en_i = 4'b1111; step(3);
    cmp("R10", "periph irq ignored in sleep", int'(mode_o), 3);
    irq_i = '0; ctm_irq_i = 1; step();
    cmp("R12", "restore cycle cpu off", int'(cpu_clk_en), 0);
    cmp("R12", "restore cycle hosc", int'(hosc_en), 1);
    quiet(); step();
    cmp("R12", "cpu released", int'(cpu_clk_en), 1);
    step();

    // R10: sleep with low-speed osc off: timer ignored, port irq wakes
    losc_run_i = 0;
    request(2'b11);
    ctm_irq_i = 1; step(3);
    cmp("R10", "timer ignored in sleep", int'(mode_o), 3);
    port_irq_i = 2'b01; step(2);
    cmp("R10", "port irq sleep wake", int'(mode_o), 0);
    quiet(); step();

    // R8: NMI from sleep
    request(2'b11); step();
    nmi_i = 1; step(); nmi_i = 0; step(2);
    cmp("R8", "nmi sleep wake", int'(mode_o), 0);

    // R7: reset while in deep halt
    request(2'b10); step();
    rst_n = 0; #1;
    cmp("R7", "reset exits standby", int'(mode_o), 0);
    step(); rst_n = 1; step(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule